// File: doc/BRIEF.md
# NOR flash status register model

This block is a cycle-level behavioural model of the status-read path of a parallel NOR flash program/erase controller. It holds a small word array split into equal blocks. It accepts simplified one-cycle command strobes with no unlock sequence: program a word, erase a block (with more blocks added during a short selection window), erase the whole chip, suspend and resume an erase, flag an aborted buffered program, clear that abort, and a general reset that leaves the error state.

While an operation is running, a read returns a status byte instead of array data. In read mode it returns the stored word. The status byte reports four flags. The error flag sits on bit 5. The erase-started flag sits on bit 3. The alternating flag on bit 2 inverts only on status reads whose address falls in a block that is being erased, or in a block that failed. The buffered-abort flag sits on bit 1.

A per-block protect mask keeps blocks out of any erase. A per-block fault input lets a testbench force an erase failure. Reads are registered, so `rd_data` holds the result one clock after `rd_en`.

Top module: `nor_status_model`

## Requirements
- R1: After reset the model is in read mode and every word reads 0xFF. In read mode a read returns the stored word.
- R2: Program (op code 0) stores old AND new data after 4 cycles and then returns to read mode. While the program runs, every read returns the status byte 0x00.
- R3: A program whose data asks for any 0 bit to become 1 ends in the error state. In that state every address reads status with bit 5 set. The word keeps its zeros, because the stored value is still old AND new.
- R4: Block erase (op code 1; the block is address bits 4:3, with 8 words per block) opens a selection window. The window lasts 8 cycles after the most recent block erase command, and status bit 3 reads 0 throughout it. A further block erase command inside the window adds its block and restarts the window.
- R5: Once erasing has begun, status bit 3 reads 1. Block erase commands that arrive after that point are ignored.
- R6: An erase sets every word of each selected, unprotected block to 0xFF. On success the model returns to read mode. A block whose protect bit is set is left untouched.
- R7: While an erase runs, status bit 2 inverts on each status read whose address lies in a block being erased. It holds its value on reads elsewhere, and a protected block counts as "elsewhere".
- R8: Chip erase (op code 2) selects every unprotected block and skips the selection window, so status bit 3 reads 1 on the first read after the command.
- R9: Suspend (op code 3) freezes a running erase. Reads outside the erase set then return array data. Reads inside it return status, with bit 3 at 1 and bit 2 inverting. Resume (op code 4) continues the erase to completion.
- R10: A block whose fault input is high at its erase step is left unchanged, and the erase ends in the error state with bit 5 set. Afterwards bit 2 inverts on reads from failed blocks and holds on reads from blocks that erased correctly.
- R11: Buffer abort (op code 5) enters a status state with bit 1 set at every address. General reset does not leave this state. Only abort-clear (op code 6) returns the model to read mode.
- R12: General reset (op code 7) clears the error flag and returns the model from the error state to read mode.
- R13: Status bits 7, 6, 4 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | 5 | Word address for program or block erase |
| cmd_data | input | 8 | Program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read address |
| prot_mask | input | 4 | Per-block protect, 1 keeps the block out of erase |
| fault_inj | input | 4 | Per-block forced erase failure |
| rd_data | output | 8 | Registered read result, array word or status byte |

## Verification
A wrong controller state shows on the next registered read. A missed transition returns status where a stored word was expected, or the reverse, and a selection window closed too early or too late flips bit 3 on the read at the window edge. A wrong erase or failure set shows as bit 2 holding when it should invert, or inverting when it should hold, across two back-to-back reads of one address. A wrong array write or erase is only visible once read mode returns, so every operation is followed by a read-back of the words it touched and of a neighbouring protected or failed block.

// File: rtl/nor_stat_pkg.sv
// Package: controller states, command codes and status bit positions
// shared by the status model, its submodules and its checker.
package nor_stat_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG,
        ST_ETIMER,
        ST_ERASE,
        ST_SUSP,
        ST_ERR,
        ST_ABORT
    } pe_state_e;

    typedef enum logic [2:0] {
        OP_PROG        = 3'd0,
        OP_BLK_ERASE   = 3'd1,
        OP_CHIP_ERASE  = 3'd2,
        OP_SUSPEND     = 3'd3,
        OP_RESUME      = 3'd4,
        OP_BUF_ABORT   = 3'd5,
        OP_ABORT_CLR   = 3'd6,
        OP_RESET       = 3'd7
    } pe_op_e;

    localparam int BIT_ERR = 5;
    localparam int BIT_TMR = 3;
    localparam int BIT_ALT = 2;
    localparam int BIT_ABT = 1;

endpackage

// File: rtl/nor_word_array.sv
// Word storage for the status model.
// Does: holds NB*WPB words. A program write ANDs new data into one word, and a
// block erase sets every word of one block to all ones. Reset fills it with ones.
// Assumes: NB*WPB is a power of two, and a program and an erase never land
// in the same cycle (the controller guarantees this).
module nor_word_array #(
    parameter int NB  = 4,
    parameter int WPB = 8,
    parameter int DW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NB*WPB)-1:0]   wr_addr,
    input  logic [DW-1:0]               wr_data,
    input  logic                        ers_en,
    input  logic [$clog2(NB)-1:0]       ers_blk,
    input  logic [$clog2(NB*WPB)-1:0]   rd_addr,
    output logic [DW-1:0]               rd_word,
    input  logic [$clog2(NB*WPB)-1:0]   cmp_addr,
    output logic [DW-1:0]               cmp_word
);
    localparam int NW = NB * WPB;

    logic [DW-1:0] mem [NW];

    // Update storage: reset to ones, AND-program one word, or erase a block.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++) begin
            if (!rst_n) begin
                mem[i] <= '1;
            end else if (wr_en && i == int'(wr_addr)) begin
                mem[i] <= mem[i] & wr_data;
            end else if (ers_en && (i / WPB) == int'(ers_blk)) begin
                mem[i] <= '1;
            end
        end
    end

    // Two combinational read ports: bus read and pre-program compare.
    always_comb begin
        rd_word  = mem[rd_addr];
        cmp_word = mem[cmp_addr];
    end
endmodule

// File: rtl/nor_pe_ctrl.sv
// Program/erase controller for the status model.
// Does: decodes command strobes and sequences the program, the block
// selection window, the per-block erase walk, suspend, failure and abort.
// It drives write and erase strobes into the array, and it exposes its state
// and its erase and failure sets to the status read path.
// Assumes: NB is a power of two and at least 2, and commands that do not
// apply in the current state are ignored.
module nor_pe_ctrl
    import nor_stat_pkg::*;
#(
    parameter int NB        = 4,
    parameter int WPB       = 8,
    parameter int DW        = 8,
    parameter int TIMER_CYC = 8,
    parameter int ERASE_CYC = 16,
    parameter int PROG_CYC  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  pe_op_e                      cmd_op,
    input  logic [$clog2(NB*WPB)-1:0]   cmd_addr,
    input  logic [DW-1:0]               cmd_data,
    input  logic [DW-1:0]               old_word,
    input  logic [NB-1:0]               prot_mask,
    input  logic [NB-1:0]               fault_inj,
    output pe_state_e                   state,
    output logic [NB-1:0]               erase_set,
    output logic [NB-1:0]               fail_mask,
    output logic                        prog_we,
    output logic [$clog2(NB*WPB)-1:0]   prog_addr,
    output logic [DW-1:0]               prog_data,
    output logic                        ers_we,
    output logic [$clog2(NB)-1:0]       ers_blk
);
    localparam int AW   = $clog2(NB * WPB);
    localparam int BW   = $clog2(NB);
    localparam int MAX1 = (TIMER_CYC > ERASE_CYC) ? TIMER_CYC : ERASE_CYC;
    localparam int MAXC = (MAX1 > PROG_CYC) ? MAX1 : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0]  cnt;
    logic [BW-1:0]  blk_ptr;
    logic           prog_bad;
    logic [NB-1:0]  sel_1h;
    logic [NB-1:0]  fail_nxt;
    logic           blk_done;
    logic           blk_last;
    logic           susp_req;

    // Decode the addressed block and the per-block erase step condition.
    always_comb begin
        sel_1h   = NB'(1) << cmd_addr[AW-1 -: BW];
        susp_req = cmd_valid && cmd_op == OP_SUSPEND;
        blk_done = !erase_set[blk_ptr] || cnt == '0;
        blk_last = blk_ptr == BW'(NB - 1);
        fail_nxt = fail_mask |
                   ((NB'(1) << blk_ptr) & {NB{erase_set[blk_ptr] & fault_inj[blk_ptr]}});
    end

    // Strobes into the array.
    always_comb begin
        prog_we = state == ST_PROG && cnt == '0;
        ers_we  = state == ST_ERASE && !susp_req && cnt == '0 &&
                  erase_set[blk_ptr] && !fault_inj[blk_ptr];
        ers_blk = blk_ptr;
    end

    // Controller state machine with its shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READ;
            cnt       <= '0;
            blk_ptr   <= '0;
            erase_set <= '0;
            fail_mask <= '0;
            prog_addr <= '0;
            prog_data <= '0;
            prog_bad  <= 1'b0;
        end else begin
            case (state)
                ST_READ: begin
                    if (cmd_valid) begin
                        case (cmd_op)
                            OP_PROG: begin
                                state     <= ST_PROG;
                                cnt       <= CW'(PROG_CYC - 1);
                                prog_addr <= cmd_addr;
                                prog_data <= cmd_data;
                                prog_bad  <= |(cmd_data & ~old_word);
                            end
                            OP_BLK_ERASE: begin
                                state     <= ST_ETIMER;
                                cnt       <= CW'(TIMER_CYC - 1);
                                erase_set <= sel_1h & ~prot_mask;
                                fail_mask <= '0;
                            end
                            OP_CHIP_ERASE: begin
                                state     <= ST_ERASE;
                                cnt       <= CW'(ERASE_CYC - 1);
                                blk_ptr   <= '0;
                                erase_set <= ~prot_mask;
                                fail_mask <= '0;
                            end
                            OP_BUF_ABORT: state <= ST_ABORT;
                            default: ;
                        endcase
                    end
                end
                ST_PROG: begin
                    if (cnt == '0) begin
                        state     <= prog_bad ? ST_ERR : ST_READ;
                        fail_mask <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ETIMER: begin
                    if (cmd_valid && cmd_op == OP_BLK_ERASE) begin
                        erase_set <= erase_set | (sel_1h & ~prot_mask);
                        cnt       <= CW'(TIMER_CYC - 1);
                    end else if (cnt == '0) begin
                        state   <= ST_ERASE;
                        cnt     <= CW'(ERASE_CYC - 1);
                        blk_ptr <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (susp_req) begin
                        state <= ST_SUSP;
                    end else if (blk_done) begin
                        fail_mask <= fail_nxt;
                        cnt       <= CW'(ERASE_CYC - 1);
                        if (blk_last) begin
                            state <= (|fail_nxt) ? ST_ERR : ST_READ;
                        end else begin
                            blk_ptr <= blk_ptr + 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (cmd_valid && cmd_op == OP_RESUME) state <= ST_ERASE;
                end
                ST_ERR: begin
                    if (cmd_valid && cmd_op == OP_RESET) begin
                        state     <= ST_READ;
                        fail_mask <= '0;
                    end
                end
                ST_ABORT: begin
                    if (cmd_valid && cmd_op == OP_ABORT_CLR) state <= ST_READ;
                end
                default: state <= ST_READ;
            endcase
        end
    end
endmodule

// File: rtl/nor_stat_read.sv
// Read path for the status model.
// Does: chooses between array data and the status byte for each read, based
// on the controller state and the block of the read address. It holds the
// alternating flag, which inverts on status reads in the toggle set, and it
// registers the result.
// Assumes: DW is at least 8, so the status byte fits in a word.
module nor_stat_read
    import nor_stat_pkg::*;
#(
    parameter int NB  = 4,
    parameter int WPB = 8,
    parameter int DW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  logic [$clog2(NB*WPB)-1:0]   rd_addr,
    input  pe_state_e                   state,
    input  logic [NB-1:0]               erase_set,
    input  logic [NB-1:0]               fail_mask,
    input  logic [DW-1:0]               arr_word,
    output logic [DW-1:0]               rd_data,
    output logic                        rd_stat,
    output logic                        alt_tgl
);
    localparam int AW = $clog2(NB * WPB);
    localparam int BW = $clog2(NB);

    logic [BW-1:0] rd_blk;
    logic [NB-1:0] tgl_set;
    logic          stat_sel;
    logic [DW-1:0] stat_byte;

    // Pick the toggle set for the current state and decide status or data.
    always_comb begin
        rd_blk = rd_addr[AW-1 -: BW];
        case (state)
            ST_ETIMER, ST_ERASE, ST_SUSP: tgl_set = erase_set;
            ST_ERR:                        tgl_set = fail_mask;
            default:                       tgl_set = '0;
        endcase
        stat_sel = state != ST_READ && !(state == ST_SUSP && !erase_set[rd_blk]);
    end

    // Compose the status byte; all other bit positions stay zero.
    always_comb begin
        stat_byte          = '0;
        stat_byte[BIT_ERR] = state == ST_ERR;
        stat_byte[BIT_TMR] = state == ST_ERASE || state == ST_SUSP;
        stat_byte[BIT_ALT] = alt_tgl;
        stat_byte[BIT_ABT] = state == ST_ABORT;
    end

    // Register the read result and advance the alternating flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_stat <= 1'b0;
            alt_tgl <= 1'b0;
        end else if (rd_en) begin
            rd_data <= stat_sel ? stat_byte : arr_word;
            rd_stat <= stat_sel;
            alt_tgl <= alt_tgl ^ (stat_sel && tgl_set[rd_blk]);
        end
    end
endmodule

// File: rtl/nor_status_model.sv
// Top level of the NOR flash status model.
// Does: ties the controller, the word array and the read path together.
// Assumes: at most one command per cycle, and reads and commands are
// driven by the same clock domain.
module nor_status_model
    import nor_stat_pkg::*;
#(
    parameter int NB        = 4,
    parameter int WPB       = 8,
    parameter int DW        = 8,
    parameter int TIMER_CYC = 8,
    parameter int ERASE_CYC = 16,
    parameter int PROG_CYC  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [$clog2(NB*WPB)-1:0]   cmd_addr,
    input  logic [DW-1:0]               cmd_data,
    input  logic                        rd_en,
    input  logic [$clog2(NB*WPB)-1:0]   rd_addr,
    input  logic [NB-1:0]               prot_mask,
    input  logic [NB-1:0]               fault_inj,
    output logic [DW-1:0]               rd_data
);
    localparam int AW = $clog2(NB * WPB);
    localparam int BW = $clog2(NB);

    pe_state_e      st;
    logic [NB-1:0]  erase_set;
    logic [NB-1:0]  fail_mask;
    logic           prog_we;
    logic [AW-1:0]  prog_addr;
    logic [DW-1:0]  prog_data;
    logic           ers_we;
    logic [BW-1:0]  ers_blk;
    logic [DW-1:0]  arr_word;
    logic [DW-1:0]  old_word;
    logic           rd_stat;
    logic           alt_tgl;

    nor_pe_ctrl #(
        .NB(NB), .WPB(WPB), .DW(DW),
        .TIMER_CYC(TIMER_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (pe_op_e'(cmd_op)),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .old_word  (old_word),
        .prot_mask (prot_mask),
        .fault_inj (fault_inj),
        .state     (st),
        .erase_set (erase_set),
        .fail_mask (fail_mask),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .ers_we    (ers_we),
        .ers_blk   (ers_blk)
    );

    nor_word_array #(.NB(NB), .WPB(WPB), .DW(DW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (prog_we),
        .wr_addr  (prog_addr),
        .wr_data  (prog_data),
        .ers_en   (ers_we),
        .ers_blk  (ers_blk),
        .rd_addr  (rd_addr),
        .rd_word  (arr_word),
        .cmp_addr (cmd_addr),
        .cmp_word (old_word)
    );

    nor_stat_read #(.NB(NB), .WPB(WPB), .DW(DW)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .state     (st),
        .erase_set (erase_set),
        .fail_mask (fail_mask),
        .arr_word  (arr_word),
        .rd_data   (rd_data),
        .rd_stat   (rd_stat),
        .alt_tgl   (alt_tgl)
    );
endmodule

// File: rtl/nor_status_chk.sv
// Checker for the NOR flash status model, bound to the top level.
// Does: relates controller state, read requests and read results over time.
module nor_status_chk
    import nor_stat_pkg::*;
#(
    parameter int NB = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic            rd_en,
    input  logic [DW-1:0]   rd_data,
    input  logic            rd_stat,
    input  logic            alt_tgl,
    input  logic [DW-1:0]   arr_word,
    input  logic [NB-1:0]   erase_set,
    input  pe_state_e       st
);
    p_read_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && rd_en) |=> rd_data == $past(arr_word));

    p_err_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && rd_en) |=> rd_data[BIT_ERR]);

    p_window_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ETIMER && rd_en) |=> !rd_data[BIT_TMR]);

    p_window_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && rd_en) |=> rd_data[BIT_TMR]);

    p_set_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE) |=> $stable(erase_set));

    p_tgl_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alt_tgl) |-> $past(rd_en));

    p_abort_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ABORT && !(cmd_valid && cmd_op == OP_ABORT_CLR)) |=> st == ST_ABORT);

    p_unused_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (rd_data[7] == 1'b0 && rd_data[6] == 1'b0 &&
                     rd_data[4] == 1'b0 && rd_data[0] == 1'b0));
endmodule

bind nor_status_model nor_status_chk #(.NB(NB), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_stat   (rd_stat),
    .alt_tgl   (alt_tgl),
    .arr_word  (arr_word),
    .erase_set (erase_set),
    .st        (st)
);

// File: tb/nor_status_model_tb.sv
// Testbench for nor_status_model: a vector table walked by a single loop,
// then directed tests for the selection window, toggling, suspend, failure,
// abort and reset.
module nor_status_model_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [4:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [3:0] prot_mask = '0;
    logic [3:0] fault_inj = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [2:0] C_PROG = 3'd0, C_BER = 3'd1, C_CER = 3'd2, C_SUS = 3'd3,
                           C_RES = 3'd4, C_ABT = 3'd5, C_ACL = 3'd6, C_RST = 3'd7;
    localparam logic [1:0] K_CMD = 2'd0, K_RD = 2'd1, K_WAIT = 2'd2;

    // vector: kind, op, addr, data (or wait count), expected, requirement
    localparam int NV = 18;
    localparam logic [29:0] VECS [NV] = '{
        {K_RD,   C_PROG, 5'd0,  8'h00, 8'hFF, 4'd1},   // R1 erased after reset
        {K_CMD,  C_PROG, 5'd5,  8'h3C, 8'h00, 4'd2},
        {K_RD,   C_PROG, 5'd5,  8'h00, 8'h00, 4'd2},   // R2 status while busy
        {K_WAIT, C_PROG, 5'd0,  8'd6,  8'h00, 4'd0},
        {K_RD,   C_PROG, 5'd5,  8'h00, 8'h3C, 4'd2},   // R2 programmed value
        {K_CMD,  C_PROG, 5'd5,  8'h1C, 8'h00, 4'd2},
        {K_WAIT, C_PROG, 5'd0,  8'd6,  8'h00, 4'd0},
        {K_RD,   C_PROG, 5'd5,  8'h00, 8'h1C, 4'd2},   // R2 clears more bits
        {K_CMD,  C_PROG, 5'd5,  8'hFF, 8'h00, 4'd3},
        {K_WAIT, C_PROG, 5'd0,  8'd6,  8'h00, 4'd0},
        {K_RD,   C_PROG, 5'd5,  8'h00, 8'h20, 4'd3},   // R3 error flag
        {K_RD,   C_PROG, 5'd30, 8'h00, 8'h20, 4'd13},  // R13 other bits zero
        {K_CMD,  C_RST,  5'd0,  8'h00, 8'h00, 4'd12},
        {K_RD,   C_PROG, 5'd5,  8'h00, 8'h1C, 4'd12},  // R12 back to data, zeros kept
        {K_CMD,  C_BER,  5'd2,  8'h00, 8'h00, 4'd4},
        {K_RD,   C_PROG, 5'd20, 8'h00, 8'h00, 4'd4},   // R4 timer bit 0
        {K_WAIT, C_PROG, 5'd0,  8'd40, 8'h00, 4'd0},
        {K_RD,   C_PROG, 5'd5,  8'h00, 8'hFF, 4'd6}    // R6 block erased
    };

    nor_status_model u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .prot_mask(prot_mask), .fault_inj(fault_inj), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] a, b;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VECS[i];
            case (v[29:28])
                K_CMD:  cmd(v[27:25], v[24:20], v[19:12]);
                K_WAIT: idle(int'(v[19:12]));
                default: begin
                    rd(v[24:20], a);
                    chk($sformatf("R%0d", v[3:0]), a, v[11:4]);
                end
            endcase
        end

        // R4 / R5: window restarts on a second selection, then closes
        cmd(C_PROG, 5'd9, 8'h00);  idle(6);
        cmd(C_PROG, 5'd17, 8'h00); idle(6);
        cmd(C_PROG, 5'd1, 8'h00);  idle(6);
        cmd(C_BER, 5'd9, 8'h00);   idle(3);
        cmd(C_BER, 5'd17, 8'h00);  idle(6);
        rd(5'd25, a); chk("R4 window open at cycle 7", {7'd0, a[3]}, 8'd0);
        rd(5'd25, a); chk("R4 window open at cycle 8", {7'd0, a[3]}, 8'd0);
        rd(5'd25, a); chk("R5 erasing started", {7'd0, a[3]}, 8'd1);
        cmd(C_BER, 5'd1, 8'h00);
        idle(80);
        rd(5'd9, a);  chk("R4 first block erased", a, 8'hFF);
        rd(5'd17, a); chk("R4 added block erased", a, 8'hFF);
        rd(5'd1, a);  chk("R5 late selection ignored", a, 8'h00);

        // R7 / R6: toggling inside the erase set only, protected block untouched
        prot_mask = 4'b0100;
        cmd(C_PROG, 5'd9, 8'h00);  idle(6);
        cmd(C_PROG, 5'd17, 8'h55); idle(6);
        cmd(C_BER, 5'd9, 8'h00);
        cmd(C_BER, 5'd17, 8'h00);
        idle(12);
        rd(5'd17, a); rd(5'd17, b); chk("R7 protected block holds bit2", {7'd0, a[2] ^ b[2]}, 8'd0);
        rd(5'd9, a);  rd(5'd9, b);  chk("R7 erasing block inverts bit2", {7'd0, a[2] ^ b[2]}, 8'd1);
        rd(5'd25, a); rd(5'd25, b); chk("R7 other block holds bit2", {7'd0, a[2] ^ b[2]}, 8'd0);
        idle(60);
        rd(5'd17, a); chk("R6 protected block kept", a, 8'h55);
        rd(5'd9, a);  chk("R6 selected block erased", a, 8'hFF);
        prot_mask = 4'b0000;

        // R8: chip erase has no selection window
        cmd(C_PROG, 5'd30, 8'h00); idle(6);
        cmd(C_CER, 5'd0, 8'h00);
        rd(5'd30, a); chk("R8 bit3 set at once", {7'd0, a[3]}, 8'd1);
        idle(80);
        rd(5'd30, a); chk("R8 chip erased", a, 8'hFF);
        rd(5'd17, a); chk("R8 chip erased other block", a, 8'hFF);

        // R9: suspend serves data outside the set, status inside
        cmd(C_PROG, 5'd3, 8'h00);  idle(6);
        cmd(C_PROG, 5'd12, 8'h33); idle(6);
        cmd(C_BER, 5'd3, 8'h00);
        idle(12);
        cmd(C_SUS, 5'd0, 8'h00);
        rd(5'd12, a); chk("R9 data outside set", a, 8'h33);
        rd(5'd3, a); rd(5'd3, b);
        chk("R9 bit2 inverts in set", {7'd0, a[2] ^ b[2]}, 8'd1);
        chk("R9 bit3 in suspend", {7'd0, b[3]}, 8'd1);
        idle(100);
        rd(5'd3, a); chk("R9 suspend holds", {7'd0, a[3]}, 8'd1);
        cmd(C_RES, 5'd0, 8'h00);
        idle(40);
        rd(5'd3, a); chk("R9 erase resumed and done", a, 8'hFF);

        // R10: injected failure, toggling only on the failed block
        cmd(C_PROG, 5'd3, 8'h00);  idle(6);
        cmd(C_PROG, 5'd11, 8'h00); idle(6);
        fault_inj = 4'b0010;
        cmd(C_BER, 5'd3, 8'h00);
        cmd(C_BER, 5'd11, 8'h00);
        idle(60);
        rd(5'd11, a); rd(5'd11, b);
        chk("R10 error flag", {7'd0, b[5]}, 8'd1);
        chk("R10 failed block inverts bit2", {7'd0, a[2] ^ b[2]}, 8'd1);
        rd(5'd3, a); rd(5'd3, b);
        chk("R10 good block holds bit2", {7'd0, a[2] ^ b[2]}, 8'd0);
        cmd(C_RST, 5'd0, 8'h00);
        fault_inj = 4'b0000;
        rd(5'd11, a); chk("R10 failed block unchanged", a, 8'h00);
        rd(5'd3, a);  chk("R12 read mode after reset cmd", a, 8'hFF);

        // R11: abort flag sticks through general reset
        cmd(C_ABT, 5'd0, 8'h00);
        rd(5'd7, a);
        chk("R11 abort flag", {7'd0, a[1]}, 8'd1);
        chk("R13 unused bits in abort", a & 8'hD1, 8'h00);
        cmd(C_RST, 5'd0, 8'h00);
        rd(5'd7, a); chk("R11 reset cmd ignored", {7'd0, a[1]}, 8'd1);
        cmd(C_ACL, 5'd0, 8'h00);
        rd(5'd7, a); chk("R11 abort clear returns data", a, 8'hFF);

        // R1: hardware reset restores the erased array
        cmd(C_PROG, 5'd0, 8'h00); idle(6);
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        rd(5'd0, a); chk("R1 reset restores array", a, 8'hFF);

        finish_run();
    end
endmodule